// File: doc/BRIEF.md
# Low-Power Mode Controller

This block holds the operating mode of a small microcontroller and decides every move between its four modes: full-speed run, low-power run, stop, and low-power stop. A stop-instruction strobe, together with a three-bit stop-mode select and a pair of enable bits, picks the stop mode to enter. An asynchronous wake interrupt, synchronised on the block clock, brings the controller back out. Where the wake lands depends on how the low-power stop was entered and on a wake-to-run control bit.

From the mode the controller derives clock-gate enables for the CPU/bus domain and the peripheral domain, and a regulator-stop indication for the supply. A stop instruction issued while both enable bits are clear enters no stop mode. Instead it raises a reset request or pulses an illegal-instruction exception. A level request input moves the part between run and low-power run. An asynchronous active-low system reset forces full-speed run.

Top module: `lpm_ctrl`

## Requirements
- R1: While and after reset, `mode` is 0 (full run), both clock enables are 1, and `reg_stop`, `rst_req`, `illegal_exc` and `wake_done` are 0.
- R2: A `stop_strobe` in full run with select 3'b000 and `stop_en` or `wait_en` set moves `mode` to 2 (stop) on the next clock edge. Mode codes: run=0, low-power run=1, stop=2, low-power stop=3.
- R3: A `stop_strobe` in low-power run with select 3'b010 and a stop enable set moves `mode` to 3. A later wake with `wake_to_run`=0 returns `mode` to 1.
- R4: A `stop_strobe` in full run with select 3'b010 and a stop enable set also moves `mode` to 3. A later wake from that entry returns `mode` to 0 whatever `wake_to_run` is.
- R5: A wake in mode 3 entered from low-power run, with `wake_to_run`=1, returns `mode` to 0.
- R6: In modes 2 and 3 `per_clk_en` is 0. `cpu_clk_en` is 0 unless `dbg_en` was 1 on the stop-entry edge, in which case it stays 1. In modes 0 and 1 both enables are 1.
- R7: `reg_stop` is 1 exactly when `mode` is 1 or 3.
- R8: A `stop_strobe` in mode 0 or 1 with `stop_en`=`wait_en`=0 leaves `mode` unchanged. With `irst_dis`=0, `rst_req` rises on the next edge and holds until reset. With `irst_dis`=1, `illegal_exc` is 1 for exactly one cycle.
- R9: Select codes other than 3'b000 and 3'b010, and 3'b000 issued from mode 1, leave `mode` unchanged.
- R10: `wake_irq` is synchronised through two flops. A stop mode is left on the third rising edge that samples `wake_irq` high, and `wake_irq` has no effect in modes 0 and 1.
- R11: `wake_done` is 1 for exactly the first cycle after each exit from mode 2 or 3.
- R12: With no strobe, `lp_req`=1 in mode 0 moves to mode 1 on the next edge, and `lp_req`=0 in mode 1 moves to mode 0. A strobe takes priority over `lp_req`.
- R13: Asserting `rst_n` low forces `mode` to 0 at once, from any mode, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| stop_strobe | input | 1 | One-cycle stop-instruction strobe |
| stop_sel | input | 3 | Stop-mode select field |
| stop_en | input | 1 | Stop enable |
| wait_en | input | 1 | Wait enable |
| wake_to_run | input | 1 | Wake from low-power stop goes to full run |
| irst_dis | input | 1 | 1: disabled stop traps as an exception; 0: as a reset |
| dbg_en | input | 1 | Debug enable; keeps CPU clock in stop modes |
| lp_req | input | 1 | Level request for low-power run |
| wake_irq | input | 1 | Asynchronous wake interrupt |
| mode | output | 2 | Current mode code |
| cpu_clk_en | output | 1 | CPU and bus clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| reg_stop | output | 1 | Regulator in stop regulation |
| rst_req | output | 1 | Sticky reset request |
| illegal_exc | output | 1 | One-cycle illegal-instruction exception |
| wake_done | output | 1 | One-cycle strobe on stop exit |

## Verification
A strobe-driven result (a mode change, `illegal_exc`, or `rst_req`) is due one rising edge after the edge that samples the strobe. A wake is due on the third edge after `wake_irq` is first sampled, because two synchroniser flops sit in front of the state register. `wake_done` arrives on the same edge as the exit. The bench drives inputs on the falling edge and compares every output on the next falling edge against a cycle model. That model carries its own two-stage wake delay, so each comparison lands one full edge after the registers it depends on have moved. Directed sequences additionally confirm the stop mode is still held two edges into a wake.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_VLPR = 2'd1,
    MODE_STOP = 2'd2,
    MODE_VLPS = 2'd3
  } lpm_mode_e;

  function automatic logic mode_is_stop(lpm_mode_e m);
    return (m == MODE_STOP) || (m == MODE_VLPS);
  endfunction

  function automatic logic mode_lowv(lpm_mode_e m);
    return (m == MODE_VLPR) || (m == MODE_VLPS);
  endfunction

  // Landing mode for a wake taken in a stop mode.
  function automatic lpm_mode_e wake_dest(lpm_mode_e m, logic from_run, logic to_run);
    case (m)
      MODE_STOP: return MODE_RUN;
      MODE_VLPS: return (from_run || to_run) ? MODE_RUN : MODE_VLPR;
      default:   return m;
    endcase
  endfunction

endpackage

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = sh_q[STAGES-1];
endmodule

// File: rtl/lpm_stop_decode.sv
module lpm_stop_decode
  import lpm_pkg::*;
#(
  parameter int                SEL_W     = 3,
  parameter logic [SEL_W-1:0]  CODE_STOP = '0,
  parameter logic [SEL_W-1:0]  CODE_VLPS = SEL_W'(2)
) (
  input  lpm_mode_e         mode,
  input  logic              strobe,
  input  logic [SEL_W-1:0]  sel,
  input  logic              stop_en,
  input  logic              wait_en,
  input  logic              irst_dis,
  output logic              enter_stop,
  output logic              enter_vlps,
  output logic              vlps_from_run,
  output logic              trap_reset,
  output logic              trap_exc
);
  logic allowed;
  logic armed;

  always_comb begin
    allowed       = strobe && !mode_is_stop(mode);
    armed         = stop_en || wait_en;
    trap_reset    = allowed && !armed && !irst_dis;
    trap_exc      = allowed && !armed &&  irst_dis;
    enter_stop    = allowed && armed && (sel == CODE_STOP) && (mode == MODE_RUN);
    enter_vlps    = allowed && armed && (sel == CODE_VLPS);
    vlps_from_run = enter_vlps && (mode == MODE_RUN);
  end

  // R9: at most one outcome per strobe
  always_comb begin
    a_r9_one_outcome: assert ($onehot0({enter_stop, enter_vlps, trap_reset, trap_exc}));
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int                SEL_W       = 3,
  parameter logic [SEL_W-1:0]  CODE_STOP   = '0,
  parameter logic [SEL_W-1:0]  CODE_VLPS   = SEL_W'(2),
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_strobe,
  input  logic [SEL_W-1:0]  stop_sel,
  input  logic              stop_en,
  input  logic              wait_en,
  input  logic              wake_to_run,
  input  logic              irst_dis,
  input  logic              dbg_en,
  input  logic              lp_req,
  input  logic              wake_irq,
  output logic [1:0]        mode,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              reg_stop,
  output logic              rst_req,
  output logic              illegal_exc,
  output logic              wake_done
);
  lpm_mode_e mode_q, mode_d;
  logic from_run_q, from_run_d;
  logic dbg_q, dbg_d;
  logic rst_req_q, exc_q, wake_done_q;

  // Named internal events
  logic wake_s, wake_hit;
  logic enter_stop, enter_vlps, vlps_from_run, trap_reset, trap_exc;

  lpm_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (wake_irq),
    .sync_out (wake_s)
  );

  lpm_stop_decode #(
    .SEL_W     (SEL_W),
    .CODE_STOP (CODE_STOP),
    .CODE_VLPS (CODE_VLPS)
  ) u_dec (
    .mode          (mode_q),
    .strobe        (stop_strobe),
    .sel           (stop_sel),
    .stop_en       (stop_en),
    .wait_en       (wait_en),
    .irst_dis      (irst_dis),
    .enter_stop    (enter_stop),
    .enter_vlps    (enter_vlps),
    .vlps_from_run (vlps_from_run),
    .trap_reset    (trap_reset),
    .trap_exc      (trap_exc)
  );

  assign wake_hit = wake_s && mode_is_stop(mode_q);

  always_comb begin
    mode_d     = mode_q;
    from_run_d = from_run_q;
    dbg_d      = dbg_q;
    if (wake_hit) begin
      mode_d = wake_dest(mode_q, from_run_q, wake_to_run);
    end else if (enter_stop) begin
      mode_d = MODE_STOP;
      dbg_d  = dbg_en;
    end else if (enter_vlps) begin
      mode_d     = MODE_VLPS;
      from_run_d = vlps_from_run;
      dbg_d      = dbg_en;
    end else if (!stop_strobe) begin
      if (mode_q == MODE_RUN && lp_req)        mode_d = MODE_VLPR;
      else if (mode_q == MODE_VLPR && !lp_req) mode_d = MODE_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_RUN;
      from_run_q  <= 1'b0;
      dbg_q       <= 1'b0;
      rst_req_q   <= 1'b0;
      exc_q       <= 1'b0;
      wake_done_q <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      from_run_q  <= from_run_d;
      dbg_q       <= dbg_d;
      rst_req_q   <= rst_req_q || trap_reset;
      exc_q       <= trap_exc;
      wake_done_q <= wake_hit;
    end
  end

  assign mode        = mode_q;
  assign per_clk_en  = !mode_is_stop(mode_q);
  assign cpu_clk_en  = !mode_is_stop(mode_q) || dbg_q;
  assign reg_stop    = mode_lowv(mode_q);
  assign rst_req     = rst_req_q;
  assign illegal_exc = exc_q;
  assign wake_done   = wake_done_q;

  // R2: enabled stop request with the stop code from run enters stop
  a_r2_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_strobe && (stop_en || wait_en) && stop_sel == CODE_STOP && mode_q == MODE_RUN)
    |=> (mode_q == MODE_STOP));

  // R4: low-power stop entered from run always wakes to run
  a_r4_forced_run: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_VLPS && from_run_q && wake_s) |=> (mode_q == MODE_RUN));

  // R6: debug at entry keeps the CPU clock but not the peripheral clock
  a_r6_dbg_cpu_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_stop && dbg_en) |=> (cpu_clk_en && !per_clk_en));

  // R8: reset request is sticky; exception is a pulse with no mode move
  a_r8_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  a_r8_exc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trap_exc |=> (illegal_exc && $stable(mode_q)));

  // R9: stop code from low-power run is ignored
  a_r9_vlpr_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_strobe && (stop_en || wait_en) && stop_sel == CODE_STOP && mode_q == MODE_VLPR)
    |=> (mode_q == MODE_VLPR));

  // R10: a stop mode is held until the synchronised wake arrives
  a_r10_hold_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_is_stop(mode_q) && !wake_s) |=> $stable(mode_q));

  // R11: wake_done marks a real exit from a stop mode
  a_r11_done_exit: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (!mode_is_stop(mode_q) &&
                   ($past(mode_q) == MODE_STOP || $past(mode_q) == MODE_VLPS)));
endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_strobe = 0, stop_en = 0, wait_en = 0, wake_to_run = 0;
  logic irst_dis = 0, dbg_en = 0, lp_req = 0, wake_irq = 0;
  logic [2:0] stop_sel = 3'd0;
  logic [1:0] mode;
  logic cpu_clk_en, per_clk_en, reg_stop, rst_req, illegal_exc, wake_done;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lpm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .stop_strobe(stop_strobe), .stop_sel(stop_sel),
    .stop_en(stop_en), .wait_en(wait_en), .wake_to_run(wake_to_run),
    .irst_dis(irst_dis), .dbg_en(dbg_en), .lp_req(lp_req), .wake_irq(wake_irq),
    .mode(mode), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .reg_stop(reg_stop), .rst_req(rst_req), .illegal_exc(illegal_exc),
    .wake_done(wake_done)
  );

  // Cycle model written from the requirements
  logic [1:0] m_mode;
  logic m_s1, m_s2, m_from_run, m_dbg, m_rst, m_exc, m_wd;

  function automatic bit is_stop(logic [1:0] m);
    return m == 2'd2 || m == 2'd3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 2'd0; m_s1 <= 0; m_s2 <= 0; m_from_run <= 0;
      m_dbg <= 0; m_rst <= 0; m_exc <= 0; m_wd <= 0;
    end else begin
      m_s1 <= wake_irq; m_s2 <= m_s1; m_exc <= 0; m_wd <= 0;
      if (is_stop(m_mode)) begin
        if (m_s2) begin
          m_wd <= 1;
          if (m_mode == 2'd2) m_mode <= 2'd0;
          else m_mode <= (m_from_run || wake_to_run) ? 2'd0 : 2'd1;
        end
      end else if (stop_strobe) begin
        if (!stop_en && !wait_en) begin
          if (irst_dis) m_exc <= 1; else m_rst <= 1;
        end else if (stop_sel == 3'd0 && m_mode == 2'd0) begin
          m_mode <= 2'd2; m_dbg <= dbg_en;
        end else if (stop_sel == 3'd2) begin
          m_mode <= 2'd3; m_dbg <= dbg_en; m_from_run <= (m_mode == 2'd0);
        end
      end else if (m_mode == 2'd0 && lp_req) m_mode <= 2'd1;
      else if (m_mode == 2'd1 && !lp_req) m_mode <= 2'd0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 mode", mode, m_mode);
    chk("R6 cpu_clk_en", cpu_clk_en, !is_stop(m_mode) || m_dbg);
    chk("R6 per_clk_en", per_clk_en, !is_stop(m_mode));
    chk("R7 reg_stop", reg_stop, (m_mode == 2'd1 || m_mode == 2'd3));
    chk("R8 rst_req", rst_req, m_rst);
    chk("R8 illegal_exc", illegal_exc, m_exc);
    chk("R11 wake_done", wake_done, m_wd);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic stop_req(logic [2:0] sel);
    stop_sel = sel; stop_strobe = 1; tick(); stop_strobe = 0;
  endtask

  task automatic wake_seq(string tag, int exp_mode);
    wake_irq = 1;
    tick(); tick();
    chk("R10 still stopped", is_stop(mode), 1);
    tick();
    chk("R11 done pulse", wake_done, 1);
    chk(tag, mode, exp_mode);
    wake_irq = 0;
    tick();
    chk("R11 done one cycle", wake_done, 0);
    tick(); tick();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    tick(); tick();
    rst_n = 1;
    stop_en = 1;
    tick();
    // R1
    chk("R1 mode", mode, 0);   chk("R1 cpu", cpu_clk_en, 1);
    chk("R1 per", per_clk_en, 1); chk("R1 reg", reg_stop, 0);
    chk("R1 rst", rst_req, 0); chk("R1 exc", illegal_exc, 0);
    chk("R1 done", wake_done, 0);

    // R2, R6, R10, R11
    stop_req(3'd0);
    chk("R2 enter stop", mode, 2);
    chk("R6 cpu off", cpu_clk_en, 0); chk("R6 per off", per_clk_en, 0);
    wake_irq = 1; tick(); wake_irq = 0;  // brief wake is still taken once synced
    tick();
    chk("R10 no early exit", mode, 2);
    tick(); chk("R10 exit third edge", mode, 0);
    tick(); tick();
    // R10: wake ignored in run
    wake_irq = 1; tick(); tick(); tick(); chk("R10 ignored in run", mode, 0);
    chk("R10 no done in run", wake_done, 0);
    wake_irq = 0; tick(); tick();

    // R6 debug kept
    dbg_en = 1; stop_req(3'd0); dbg_en = 0;
    chk("R6 dbg cpu on", cpu_clk_en, 1); chk("R6 dbg per off", per_clk_en, 0);
    tick(); chk("R6 dbg latched", cpu_clk_en, 1);
    wake_seq("R2 stop wake", 0);

    // R12, R7
    lp_req = 1; tick(); chk("R12 to vlpr", mode, 1); chk("R7 reg vlpr", reg_stop, 1);
    // R9
    stop_req(3'd0); chk("R9 stop code from vlpr", mode, 1);
    stop_req(3'd5); chk("R9 odd code", mode, 1);
    // R3
    wake_to_run = 0; stop_req(3'd2);
    chk("R3 enter vlps", mode, 3); chk("R7 reg vlps", reg_stop, 1);
    wake_seq("R3 wake to vlpr", 1);
    // R5
    stop_req(3'd2); chk("R5 enter vlps", mode, 3);
    lp_req = 0; wake_to_run = 1;
    wake_seq("R5 wake to run", 0);
    // R4
    wake_to_run = 0; stop_req(3'd2); chk("R4 vlps from run", mode, 3);
    wake_seq("R4 forced run", 0);
    chk("R7 reg run", reg_stop, 0);
    // R12 priority
    lp_req = 1; stop_req(3'd7); chk("R12 strobe priority", mode, 0);
    tick(); chk("R12 then vlpr", mode, 1);
    lp_req = 0; tick(); chk("R12 back to run", mode, 0);

    // R8 exception then reset request
    stop_en = 0; wait_en = 0; irst_dis = 1; stop_req(3'd0);
    chk("R8 exc", illegal_exc, 1); chk("R8 exc mode", mode, 0);
    tick(); chk("R8 exc one cycle", illegal_exc, 0);
    wait_en = 1; stop_req(3'd0); chk("R2 wait enable", mode, 2);
    wake_seq("R2 wait wake", 0);
    wait_en = 0; irst_dis = 0; stop_req(3'd2);
    chk("R8 rst req", rst_req, 1); chk("R8 rst mode", mode, 0);
    tick(); tick(); chk("R8 rst sticky", rst_req, 1);

    // R13 async reset from stop
    stop_en = 1; stop_req(3'd0); chk("R13 in stop", mode, 2);
    rst_n = 0; #1;
    chk("R13 async to run", mode, 0); chk("R13 rst_req clear", rst_req, 0);
    tick(); rst_n = 1; tick();

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      stop_strobe = ($urandom % 6) == 0;
      case ($urandom % 5)
        0, 1: stop_sel = 3'd0;
        2, 3: stop_sel = 3'd2;
        default: stop_sel = 3'($urandom);
      endcase
      stop_en     = ($urandom % 4) != 0;
      wait_en     = ($urandom % 3) == 0;
      irst_dis    = $urandom % 2;
      dbg_en      = $urandom % 2;
      wake_to_run = $urandom % 2;
      if (($urandom % 10) == 0) lp_req = ~lp_req;
      wake_irq    = ($urandom % 5) == 0;
      if ((i % 500) == 499) rst_n = 0;
      tick();
      rst_n = 1;
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule